// File: doc/BRIEF.md
# Solenoid Hold Drive PWM Generator

This block produces the pulse-width modulated waveform that keeps a solenoid energised after its attack pulse. A 4-bit divider code selects a power-of-two slowdown of the system clock. Each slowed tick advances an 8-bit period counter. That counter climbs from zero to a programmable top value and then wraps. The drive output is high while the count is below the programmed duty value. The block also emits a one-cycle marker each time the counter wraps.

Duty, top and divider code are sampled into internal working copies at two moments: while the block is disabled, and at each counter wrap. A change made in the middle of a period therefore never produces a shortened or stretched pulse. The period in system clocks is (top+1) multiplied by the divide ratio. The high time is the duty value multiplied by the same ratio.

Top module: `hold_pwm`

## Requirements
- R1: The divider code n selects a divide ratio of 2^(n-1), for n from 1 to 15. Code 0 behaves exactly like code 1. The period between two wrap markers is (top+1) * ratio system clock cycles.
- R2: Within a period, the output is high for the first min(duty, top+1) counter steps and low for the rest. This gives min(duty, top+1) * ratio high cycles per period.
- R3: A duty of 0 keeps the output low for the whole period.
- R4: A duty of 255 (all ones) keeps the output high for the whole period, whatever the top value.
- R5: When duty is at least top+1, the output stays high for the whole period.
- R6: Duty, top and divider code values applied while enabled take effect only at the next counter wrap. The period that is in progress, and the period begun by a wrap that happened before the change, keep the old values.
- R7: While the enable is low, the output and the wrap marker are low and the counter is held at zero. On the first enabled cycle the counter starts at zero with the input values present at that edge, so with ratio 1 the first wrap follows top+1 cycles after enabling.
- R8: The wrap marker is a single-cycle pulse, once per period, raised in the cycle where the counter returns to zero.
- R9: During and right after an active-low reset, the output and the wrap marker are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the output off and clears the counter |
| duty_i | input | 8 | Compare value; output high while count is below it (255 = always on) |
| top_i | input | 8 | Counter maximum; sets the period length |
| code_i | input | 4 | Divider code; ratio 2^(code-1), code 0 treated as 1 |
| pwm_o | output | 1 | Hold drive waveform |
| wrap_o | output | 1 | One-cycle pulse when the counter wraps to zero |

## Verification
The bench measures whole periods between wrap markers and compares the period and high-time counts against values computed from the divide ratio. A design that misdecoded the code, or that did not map code 0 onto code 1, would give a wrong period length. The duty extremes and the duty-above-top case are driven on purpose. A comparator that dropped the all-ones special case, or that wrapped at the wrong count, would show a low gap in a period that should be solid high. The bench changes settings right after a wrap to catch a design that loads new values early: such a design would give the period in progress the new length. Disable and re-enable sequences check that the counter restarts from zero and that the output stays off while disabled.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;
    parameter int unsigned CNT_W  = 8;
    parameter int unsigned CODE_W = 4;
    // widest prescale counter: largest code gives 2^(2^CODE_W - 2)
    parameter int unsigned PRE_W  = (1 << CODE_W) - 2;

    typedef struct packed {
        logic              active;
        logic              wrap;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  duty;
        logic [CNT_W-1:0]  top;
        logic [CODE_W-1:0] code;
    } core_st_t;
endpackage

// File: rtl/hpwm_prescale.sv
module hpwm_prescale #(
    parameter int unsigned CODE_W = hpwm_pkg::CODE_W,
    parameter int unsigned PRE_W  = hpwm_pkg::PRE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] last;

    always_comb begin
        // code_i is already normalised to at least 1
        span   = (PRE_W+1)'(1) << (code_i - CODE_W'(1));
        last   = PRE_W'(span - (PRE_W+1)'(1));
        tick_o = run_i && (pre_q == last);
        if (!run_i || tick_o) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/hpwm_core.sv
module hpwm_core
    import hpwm_pkg::*;
#(
    parameter logic [CNT_W-1:0]  RST_DUTY = CNT_W'(127),
    parameter logic [CNT_W-1:0]  RST_TOP  = CNT_W'(255),
    parameter logic [CODE_W-1:0] RST_CODE = CODE_W'(5)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic [CNT_W-1:0]  top_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              tick_i,
    output logic              pwm_o,
    output logic              wrap_o,
    output logic              active_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  top_o,
    output logic [CODE_W-1:0] code_o
);
    core_st_t st_d, st_q;
    logic     load;

    always_comb begin
        st_d        = st_q;
        st_d.wrap   = 1'b0;
        st_d.active = en_i;
        load        = 1'b0;
        if (!en_i || !st_q.active) begin
            st_d.cnt = '0;
            load     = 1'b1;
        end else if (tick_i) begin
            if (st_q.cnt == st_q.top) begin
                st_d.cnt  = '0;
                st_d.wrap = 1'b1;
                load      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (load) begin
            st_d.duty = duty_i;
            st_d.top  = top_i;
            st_d.code = (code_i == '0) ? CODE_W'(1) : code_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{active: 1'b0, wrap: 1'b0, cnt: '0,
                      duty: RST_DUTY, top: RST_TOP, code: RST_CODE};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o    = st_q.active && ((st_q.duty == '1) || (st_q.cnt < st_q.duty));
    assign wrap_o   = st_q.wrap;
    assign active_o = st_q.active;
    assign cnt_o    = st_q.cnt;
    assign duty_o   = st_q.duty;
    assign top_o    = st_q.top;
    assign code_o   = st_q.code;
endmodule

// File: rtl/hold_pwm.sv
module hold_pwm
    import hpwm_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic [CNT_W-1:0]  top_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pwm_o,
    output logic              wrap_o
);
    logic              tick;
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  duty_act;
    logic [CNT_W-1:0]  top_act;
    logic [CODE_W-1:0] code_act;

    hpwm_prescale #(.CODE_W(CODE_W), .PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (active),
        .code_i (code_act),
        .tick_o (tick)
    );

    hpwm_core u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .duty_i   (duty_i),
        .top_i    (top_i),
        .code_i   (code_i),
        .tick_i   (tick),
        .pwm_o    (pwm_o),
        .wrap_o   (wrap_o),
        .active_o (active),
        .cnt_o    (cnt),
        .duty_o   (duty_act),
        .top_o    (top_act),
        .code_o   (code_act)
    );
endmodule

// File: rtl/hold_pwm_chk.sv
module hold_pwm_chk
    import hpwm_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              en_i,
    input logic              pwm_o,
    input logic              wrap_o,
    input logic              tick,
    input logic              active,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  duty_act,
    input logic [CNT_W-1:0]  top_act,
    input logic [CODE_W-1:0] code_act
);
    // R7
    off_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!pwm_o && !wrap_o && cnt == '0));

    // R1
    count_within_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active |-> (cnt <= top_act));

    // R8
    wrap_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |-> (cnt == '0));

    // R1
    code_one_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active && code_act <= CODE_W'(1)) |-> tick);

    // R3
    zero_duty_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_act == '0) |-> !pwm_o);

    // R6
    hold_settings_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) && $past(active) && !wrap_o) |->
            ($stable(duty_act) && $stable(top_act) && $stable(code_act)));
endmodule

bind hold_pwm hold_pwm_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pwm_o    (pwm_o),
    .wrap_o   (wrap_o),
    .tick     (tick),
    .active   (active),
    .cnt      (cnt),
    .duty_act (duty_act),
    .top_act  (top_act),
    .code_act (code_act)
);

// File: tb/sim_hold_pwm.sv
`timescale 1ns/1ps
module sim_hold_pwm;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en_i = 1'b0;
    logic [7:0] duty_i = 8'd0;
    logic [7:0] top_i = 8'd0;
    logic [3:0] code_i = 4'd1;
    logic       pwm_o, wrap_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    hold_pwm u0 (.*);

    function automatic int ratio(input int code);
        int c = (code == 0) ? 1 : code;
        return 1 << (c - 1);
    endfunction

    function automatic int exp_per(input int top, input int code);
        return (top + 1) * ratio(code);
    endfunction

    function automatic int exp_hi(input int duty, input int top, input int code);
        if (duty == 255) return exp_per(top, code);
        return ((duty < top + 1) ? duty : top + 1) * ratio(code);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int d, input int t, input int c);
        duty_i = 8'(d); top_i = 8'(t); code_i = 4'(c);
    endtask

    // start at a wrap (possibly the current cycle) and measure one period
    task automatic measure(output int per, output int hi);
        int guard = 0;
        while (!wrap_o && guard < 40000) begin @(negedge clk_i); guard++; end
        per = 0; hi = 0;
        do begin
            per++;
            hi += int'(pwm_o);
            @(negedge clk_i);
        end while (!wrap_o && per < 40000);
    endtask

    task automatic run_case(input string req, input int d, input int t, input int c);
        int per, hi;
        setcfg(d, t, c);
        measure(per, hi);           // period already under way may carry old values
        @(negedge clk_i);           // step past wrap so the new settings load at the next one
        measure(per, hi);
        measure(per, hi);
        check({req, " period"}, per, exp_per(t, c));
        check({req, " high"}, hi, exp_hi(d, t, c));
    endtask

    initial begin
        int per, hi, w, k;
        repeat (3) @(negedge clk_i);
        // R9 reset state
        check("R9 pwm in reset", int'(pwm_o), 0);
        check("R9 wrap in reset", int'(wrap_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R9 pwm after reset", int'(pwm_o), 0);

        setcfg(3, 9, 1);
        en_i = 1'b1;
        run_case("R1 R2 code1", 3, 9, 1);
        run_case("R1 code0", 3, 9, 0);
        run_case("R1 R2 code3", 2, 4, 3);

        // R8 wrap count over 100 cycles with period 20
        measure(per, hi);
        w = 0;
        for (int i = 0; i < 100; i++) begin
            w += int'(wrap_o);
            @(negedge clk_i);
        end
        check("R8 wraps per 100 cycles", w, 5);

        run_case("R3 zero duty", 0, 7, 2);
        run_case("R4 full duty", 255, 255, 1);
        run_case("R5 duty above top", 20, 9, 1);
        run_case("R1 R5 code15", 1, 0, 15);

        // R6 mid-stream change only at the following wrap
        run_case("R6 setup", 2, 5, 2);
        setcfg(4, 3, 1);
        measure(per, hi);
        check("R6 old period", per, 12);
        check("R6 old high", hi, 4);
        measure(per, hi);
        check("R6 new period", per, 4);
        check("R6 new high", hi, 4);

        // R7 disable then re-enable
        setcfg(255, 3, 1);
        en_i = 1'b0;
        @(negedge clk_i);
        w = 0; k = 0;
        for (int i = 0; i < 20; i++) begin
            w += int'(wrap_o); k += int'(pwm_o);
            @(negedge clk_i);
        end
        check("R7 pwm while off", k, 0);
        check("R7 wrap while off", w, 0);
        en_i = 1'b1;
        @(negedge clk_i);
        check("R7 pwm on first enabled cycle", int'(pwm_o), 1);
        k = 0;
        while (!wrap_o && k < 100) begin @(negedge clk_i); k++; end
        check("R7 cycles to first wrap", k, 4);

        // R2 random settings, fixed seed
        void'($urandom(1234));
        for (int i = 0; i < 20; i++) begin
            int d = int'($urandom_range(0, 255));
            int t = int'($urandom_range(0, 31));
            int c = int'($urandom_range(0, 4));
            run_case("R2 random", d, t, c);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule